// File: doc/BRIEF.md
# Serial Line Error Flag Unit

This block keeps the two sticky error flags of a serial channel's status register. The overrun flag reports that a received word was lost because a new frame completed before the previous word had been taken. The second flag is shared. In asynchronous mode it reports a parity mismatch signalled by the framing logic. In synchronous mode with an external (slave) clock it reports a transmit under-run, meaning a transfer clock arrived while nothing was ready to send.

The framing, shifting and FIFO storage sit outside this block. It sees the channel configuration as static levels, plus single-cycle strobes for frame completion, receive-buffer reads, status-register reads and transfer-clock events. With the receive FIFO enabled, the overrun decision uses a registered "no space" level supplied by the FIFO. When the channel drives its own clock in synchronous mode, neither error can be generated. Both flags clear when software reads the status register. A read therefore also removes any overrun left over from a mode change.

Top module: `sio_err_flags`

## Requirements
- R1: After reset, `status` reads all zeros.
- R2: With the receive FIFO disabled, the receive buffer counts as occupied after a `frame_done` pulse. It becomes free after an `rxbuf_read` pulse. A `frame_done` while the buffer is occupied sets bit 4 of `status` on the next cycle, unless `rxbuf_read` is high in the same cycle. In that case the old word counts as taken and no overrun occurs.
- R3: With `rx_fifo_en`=1, a `frame_done` sets bit 4 only if `rx_no_space`=1 in that cycle. Buffer occupancy is ignored, and a `frame_done` in this mode leaves the buffer free.
- R4: In asynchronous mode (`sync_mode`=0), an `rx_parity_bad` pulse sets bit 3. In synchronous mode, `rx_parity_bad` has no effect.
- R5: In synchronous mode with `sclk_is_out`=0 and `dbuf_en`=1, a `xfer_clk` pulse sets bit 3 if `tx_shift_idle`=1 and `tx_dbuf_empty`=1 and the transmit FIFO condition of R6 holds.
- R6: With `tx_fifo_en`=1, under-run additionally requires `tx_fifo_empty`=1. With `tx_fifo_en`=0, `tx_fifo_empty` is ignored.
- R7: In synchronous mode with `sclk_is_out`=1, neither bit 3 nor bit 4 is ever set.
- R8: Under-run is never raised when `dbuf_en`=0 or in asynchronous mode.
- R9: A `stat_read` pulse clears bits 3 and 4 on the next cycle. Without a read, a set flag holds.
- R10: If a flag's set condition and `stat_read` fall in the same cycle, that flag is 1 afterwards.
- R11: All `status` bits other than 3 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 = synchronous I/O mode, 0 = asynchronous mode |
| sclk_is_out | input | 1 | In synchronous mode, 1 = the channel drives the clock |
| dbuf_en | input | 1 | Transmit double buffer enabled |
| rx_fifo_en | input | 1 | Receive FIFO enabled |
| rx_no_space | input | 1 | Registered: receive FIFO full or usable depth reached |
| tx_fifo_en | input | 1 | Transmit FIFO enabled |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no entry |
| frame_done | input | 1 | Strobe: reception of a frame completed |
| rx_parity_bad | input | 1 | Strobe: parity of the completed frame mismatched |
| rxbuf_read | input | 1 | Strobe: receive buffer read |
| stat_read | input | 1 | Strobe: status register read |
| xfer_clk | input | 1 | Strobe: next transfer clock arrived |
| tx_shift_idle | input | 1 | Transmit shift register has finished |
| tx_dbuf_empty | input | 1 | Transmit double buffer holds no data |
| status | output | 8 | Status register image (bit 4 overrun, bit 3 parity/under-run) |

## Verification
The shared bit 3 is swept over every combination of mode, clock direction, double-buffer enable, transfer-clock pulse, shifter idle, double-buffer empty, transmit FIFO enable and empty, and parity strobe. This separates a parity error from an under-run, and shows each gating term of R5 to R8 on its own. The overrun bit is swept over mode, clock direction, FIFO enable and "no space", with the buffer either empty or already filled and with or without a same-cycle buffer read. This tells the plain-buffer rule apart from the FIFO rule and from the clock-output suppression. Directed sequences check hold without a read, clear on read, and a set that coincides with a read.

// File: rtl/sio_err_pkg.sv
package sio_err_pkg;

   typedef enum logic [1:0] {
      LINK_ASYNC       = 2'd0,
      LINK_SYNC_SLAVE  = 2'd1,
      LINK_SYNC_MASTER = 2'd2
   } link_t;

   function automatic link_t link_decode(input logic sync_m, input logic clk_out);
      if (!sync_m)      return LINK_ASYNC;
      else if (clk_out) return LINK_SYNC_MASTER;
      else              return LINK_SYNC_SLAVE;
   endfunction

endpackage

// File: rtl/sio_flag_cell.sv
module sio_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/sio_ovr_detect.sv
module sio_ovr_detect
   import sio_err_pkg::*;
#(
   parameter bit RX_FIFO = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  link_t link,
   input  logic  fifo_en,
   input  logic  no_space,
   input  logic  frame_done,
   input  logic  buf_read,
   output logic  set_o
);
   logic use_fifo;
   logic full_hit;
   logic buf_busy, buf_busy_d;

   generate
      if (RX_FIFO) begin : g_fifo
         assign use_fifo = fifo_en;
         assign full_hit = no_space;
      end else begin : g_nofifo
         assign use_fifo = 1'b0;
         assign full_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      buf_busy_d = buf_busy;
      if (use_fifo)        buf_busy_d = 1'b0;
      else if (frame_done) buf_busy_d = 1'b1;
      else if (buf_read)   buf_busy_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_busy <= 1'b0;
      else        buf_busy <= buf_busy_d;
   end

   always_comb begin
      set_o = 1'b0;
      if (frame_done && (link != LINK_SYNC_MASTER)) begin
         if (use_fifo) set_o = full_hit;
         else          set_o = buf_busy && !buf_read;
      end
   end
endmodule

// File: rtl/sio_shared_detect.sv
module sio_shared_detect
   import sio_err_pkg::*;
#(
   parameter bit TX_FIFO = 1'b1
) (
   input  link_t link,
   input  logic  dbuf_en,
   input  logic  tx_fifo_en,
   input  logic  tx_fifo_empty,
   input  logic  xfer_clk,
   input  logic  shift_idle,
   input  logic  dbuf_empty,
   input  logic  parity_bad,
   output logic  set_o
);
   logic fifo_dry;
   logic under, par;

   generate
      if (TX_FIFO) begin : g_fifo
         assign fifo_dry = !tx_fifo_en || tx_fifo_empty;
      end else begin : g_nofifo
         assign fifo_dry = 1'b1;
      end
   endgenerate

   always_comb begin
      under = 1'b0;
      par   = 1'b0;
      case (link)
         LINK_ASYNC:      par   = parity_bad;
         LINK_SYNC_SLAVE: under = dbuf_en && xfer_clk && shift_idle
                                  && dbuf_empty && fifo_dry;
         default:         begin end
      endcase
      set_o = under || par;
   end
endmodule

// File: rtl/sio_err_flags.sv
module sio_err_flags
   import sio_err_pkg::*;
#(
   parameter int STAT_W  = 8,
   parameter int OVR_POS = 4,
   parameter int PU_POS  = 3,
   parameter bit RX_FIFO = 1'b1,
   parameter bit TX_FIFO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_mode,
   input  logic              sclk_is_out,
   input  logic              dbuf_en,
   input  logic              rx_fifo_en,
   input  logic              rx_no_space,
   input  logic              tx_fifo_en,
   input  logic              tx_fifo_empty,
   input  logic              frame_done,
   input  logic              rx_parity_bad,
   input  logic              rxbuf_read,
   input  logic              stat_read,
   input  logic              xfer_clk,
   input  logic              tx_shift_idle,
   input  logic              tx_dbuf_empty,
   output logic [STAT_W-1:0] status
);
   localparam int NFLAG = 2;

   generate
      if (OVR_POS == PU_POS) begin : g_bad_pos
         $error("sio_err_flags: flag positions must differ");
      end
      if (OVR_POS >= STAT_W || PU_POS >= STAT_W || OVR_POS < 0 || PU_POS < 0) begin : g_bad_rng
         $error("sio_err_flags: flag position outside status width");
      end
   endgenerate

   link_t            link;
   logic [NFLAG-1:0] set_v;
   logic [NFLAG-1:0] flag_q;

   assign link = link_decode(sync_mode, sclk_is_out);

   sio_ovr_detect #(.RX_FIFO(RX_FIFO)) u_ovr (
      .clk        (clk),
      .rst_n      (rst_n),
      .link       (link),
      .fifo_en    (rx_fifo_en),
      .no_space   (rx_no_space),
      .frame_done (frame_done),
      .buf_read   (rxbuf_read),
      .set_o      (set_v[0])
   );

   sio_shared_detect #(.TX_FIFO(TX_FIFO)) u_pu (
      .link          (link),
      .dbuf_en       (dbuf_en),
      .tx_fifo_en    (tx_fifo_en),
      .tx_fifo_empty (tx_fifo_empty),
      .xfer_clk      (xfer_clk),
      .shift_idle    (tx_shift_idle),
      .dbuf_empty    (tx_dbuf_empty),
      .parity_bad    (rx_parity_bad),
      .set_o         (set_v[1])
   );

   generate
      for (genvar f = 0; f < NFLAG; f++) begin : g_flag
         sio_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[f]),
            .clr_i (stat_read),
            .q_o   (flag_q[f])
         );
      end
      for (genvar b = 0; b < STAT_W; b++) begin : g_stat
         if (b == OVR_POS) begin : g_o
            assign status[b] = flag_q[0];
         end else if (b == PU_POS) begin : g_p
            assign status[b] = flag_q[1];
         end else begin : g_z
            assign status[b] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/sio_err_flags_chk.sv
module sio_err_flags_chk #(
   parameter int STAT_W  = 8,
   parameter int OVR_POS = 4,
   parameter int PU_POS  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_mode,
   input logic              sclk_is_out,
   input logic              dbuf_en,
   input logic              rx_fifo_en,
   input logic              rx_no_space,
   input logic              tx_fifo_en,
   input logic              tx_fifo_empty,
   input logic              frame_done,
   input logic              rx_parity_bad,
   input logic              stat_read,
   input logic              xfer_clk,
   input logic              tx_shift_idle,
   input logic              tx_dbuf_empty,
   input logic [STAT_W-1:0] status
);
   logic [STAT_W-1:0] other_mask;
   always_comb begin
      other_mask = '1;
      other_mask[OVR_POS] = 1'b0;
      other_mask[PU_POS]  = 1'b0;
   end

   // R7: clock-output mode with a read leaves both flags clear
   assert_master_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && sclk_is_out && stat_read) |=> (status[OVR_POS] == 1'b0 && status[PU_POS] == 1'b0));

   // R9: flags hold without a read
   assert_ovr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_read && status[OVR_POS]) |=> status[OVR_POS]);
   assert_pu_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_read && status[PU_POS]) |=> status[PU_POS]);

   // R9: read with no set event clears everything
   assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_read && !frame_done && !xfer_clk && !rx_parity_bad) |=> (status == '0));

   // R3: FIFO with space never flags overrun after a read
   assert_fifo_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fifo_en && !rx_no_space && stat_read) |=> !status[OVR_POS]);

   // R5, R10: under-run condition sets the flag even with a read
   assert_under_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !sclk_is_out && dbuf_en && xfer_clk && tx_shift_idle && tx_dbuf_empty
       && (!tx_fifo_en || tx_fifo_empty)) |=> status[PU_POS]);

   // R8: no under-run without double buffer in sync mode
   assert_no_dbuf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !dbuf_en && stat_read) |=> !status[PU_POS]);

   // R11: unused bits stay zero
   always_ff @(posedge clk) begin
      if (rst_n) assert_unused_zero_R11: assert ((status & other_mask) == '0);
   end
endmodule

bind sio_err_flags sio_err_flags_chk #(
   .STAT_W(STAT_W), .OVR_POS(OVR_POS), .PU_POS(PU_POS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .sclk_is_out(sclk_is_out),
   .dbuf_en(dbuf_en), .rx_fifo_en(rx_fifo_en), .rx_no_space(rx_no_space),
   .tx_fifo_en(tx_fifo_en), .tx_fifo_empty(tx_fifo_empty), .frame_done(frame_done),
   .rx_parity_bad(rx_parity_bad), .stat_read(stat_read), .xfer_clk(xfer_clk),
   .tx_shift_idle(tx_shift_idle), .tx_dbuf_empty(tx_dbuf_empty), .status(status)
);

// File: tb/sio_err_flags_test.sv
module sio_err_flags_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_mode = 0, sclk_is_out = 0, dbuf_en = 0, rx_fifo_en = 0, rx_no_space = 0;
   logic tx_fifo_en = 0, tx_fifo_empty = 0, frame_done = 0, rx_parity_bad = 0;
   logic rxbuf_read = 0, stat_read = 0, xfer_clk = 0, tx_shift_idle = 0, tx_dbuf_empty = 0;
   logic [7:0] status;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sio_err_flags uut (.*);

   task automatic check(input string req, input logic [7:0] exp);
      checks++;
      if (status !== exp) begin
         fails++;
         $display("FAIL %s: status=%02h expected=%02h", req, status, exp);
      end
   endtask

   // one cycle of strobes, driven at negedge, result visible at following negedge
   task automatic pulse(input logic fd, input logic rd, input logic sr,
                        input logic pb, input logic xc);
      frame_done = fd; rxbuf_read = rd; stat_read = sr; rx_parity_bad = pb; xfer_clk = xc;
      @(negedge clk);
      frame_done = 0; rxbuf_read = 0; stat_read = 0; rx_parity_bad = 0; xfer_clk = 0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: status=%02h expected=run completion", status);
      finish_run();
   end

   initial begin
      logic m_full, m_ovr, exp3, setc;
      @(negedge clk);
      check("R1 reset", 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 8'h00);

      // shared bit sweep: R4 R5 R6 R7 R8
      for (int i = 0; i < 512; i++) begin
         {sync_mode, sclk_is_out, dbuf_en, tx_shift_idle, tx_dbuf_empty,
          tx_fifo_en, tx_fifo_empty} = i[8:2];
         pulse(0, 0, 1, 0, 0);
         check("R9 clear", 8'h00);
         pulse(0, 0, 0, i[1], i[0]);
         exp3 = (sync_mode && !sclk_is_out && dbuf_en && i[0] && tx_shift_idle
                 && tx_dbuf_empty && (!tx_fifo_en || tx_fifo_empty))
              || (!sync_mode && i[1]);
         check("R4 R5 R6 R7 R8 R11 shared bit", {3'b0, 1'b0, exp3, 3'b0});
      end
      {dbuf_en, tx_shift_idle, tx_dbuf_empty, tx_fifo_en, tx_fifo_empty} = '0;

      // overrun sweep: R2 R3 R7
      m_full = 0;
      for (int i = 0; i < 64; i++) begin
         {sync_mode, sclk_is_out, rx_fifo_en, rx_no_space} = i[5:2];
         pulse(0, 1, 1, 0, 0);
         m_full = 0; m_ovr = 0;
         check("R9 clear before overrun", 8'h00);
         for (int k = 0; k < 2; k++) begin
            logic rd;
            if (k == 0 && !i[1]) continue;
            rd = (k == 1) ? i[0] : 1'b0;
            if (rx_fifo_en) setc = rx_no_space;
            else            setc = m_full && !rd;
            if (sync_mode && sclk_is_out) setc = 0;
            m_ovr = m_ovr | setc;
            m_full = rx_fifo_en ? 1'b0 : 1'b1;
            pulse(1, rd, 0, 0, 0);
            check("R2 R3 R7 overrun", {3'b0, m_ovr, 4'b0});
         end
      end

      // R9 hold and R10 coincident set and read
      {sync_mode, sclk_is_out, rx_fifo_en, rx_no_space} = 4'b0000;
      pulse(0, 1, 1, 0, 0);
      pulse(1, 0, 0, 0, 0);
      pulse(1, 0, 0, 1, 0);
      check("R2 R4 both set", 8'h18);
      repeat (5) @(negedge clk);
      check("R9 hold", 8'h18);
      pulse(1, 0, 1, 0, 0);
      check("R10 overrun set with read", 8'h10);
      pulse(0, 0, 0, 0, 0);
      check("R10 stays after", 8'h10);
      pulse(0, 0, 1, 1, 0);
      check("R10 parity set with read", 8'h08);
      pulse(0, 0, 1, 0, 0);
      check("R9 final clear", 8'h00);

      // R7 stale overrun cleared by read after leaving clock-output mode
      pulse(1, 0, 0, 0, 0);
      check("R2 stale overrun", 8'h10);
      sync_mode = 1; sclk_is_out = 1;
      pulse(1, 0, 0, 0, 0);
      check("R7 master keeps old flag", 8'h10);
      sync_mode = 0; sclk_is_out = 0;
      pulse(0, 1, 1, 0, 0);
      check("R9 read clears stale", 8'h00);

      finish_run();
   end
endmodule